// File: doc/BRIEF.md
# Deferred Page Write Controller

This block sits between the serial bus front end of a small non-volatile memory and its 256-byte storage array. It does not write bytes into the array while the bus delivers them. It gathers the bytes of one write transaction in a 16-byte page buffer and commits them only when the bus front end reports the end of the transaction. The commit runs inside a fixed, self-timed write window. During that window the block raises a busy flag, and the front end uses the flag to stop answering the bus.

The front end first sends a word address. Its upper bits pick the page and its lower four bits pick the starting offset. Each data byte after it goes to the current offset, and the offset then advances, wrapping inside the page. A per-byte valid mask records which buffer slots the transaction filled, and only those slots are written to the array. A write-protect input is sampled at the end of the transaction. When it is high, the buffered bytes are dropped and no write window starts. The window length is a parameter in system clocks, with a default of 5 ms at 50 MHz.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, busy_o is 0, mem_we_o is 0 and the page buffer holds no valid bytes.
- R2: An address strobe sets the page from addr_i[7:4] and the offset from addr_i[3:0]. Each accepted data strobe stores data_i at the current offset, and the offset then advances by one modulo 16. A later byte at the same offset replaces the earlier one, and after a gap in strobes the bytes continue at the next offset.
- R3: An accepted address strobe discards every byte buffered before it. Bytes buffered without a stop in between stay buffered.
- R4: A stop_i pulse that arrives while idle, with wp_i low and at least one valid byte buffered, raises busy_o in the next cycle. busy_o then stays high for exactly CYCLE_CLKS cycles.
- R5: During the window, each valid slot is written exactly once, in ascending offset order, to mem_addr_o = {page, offset}, with the buffered byte on mem_data_o. mem_we_o is never high outside the window, and a window holds at most 16 writes.
- R6: No array location outside the valid slots of the committed page is written.
- R7: When wp_i is high at the stop pulse, busy_o stays low, no write takes place and the buffer is emptied, so a later stop with wp_i low starts nothing.
- R8: A stop pulse with no valid byte buffered starts no window.
- R9: While busy_o is high, address strobes, data strobes and stop pulses have no effect, and the buffer is empty once the window ends.
- R10: Address and data strobes that arrive in the same cycle as a stop pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld_i | input | 1 | Word address strobe |
| addr_i | input | ADDR_W | Word address: page in the upper bits, offset in the low 4 bits |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | End of the write transaction |
| wp_i | input | 1 | Write protect, high blocks the commit |
| busy_o | output | 1 | Write window in progress |
| mem_we_o | output | 1 | Storage array write enable |
| mem_addr_o | output | ADDR_W | Storage array address |
| mem_data_o | output | DATA_W | Storage array write data |

## Verification
The bench builds the block with its default 8-bit address, 16-byte page and 8-bit data, but shortens CYCLE_CLKS to 24. A full write window then takes only a few dozen clocks. This lets the bench sweep every starting offset from 0 to 15 against every transaction length from 0 to 17 bytes, so it covers the empty stop, single bytes, full pages and wrap-around overwrites. Some of these transactions run with write protect high. Directed runs then cover strobes during the window, a second address strobe before stop, and strobes in the same cycle as stop.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic {
        PW_IDLE = 1'b0,
        PW_BUSY = 1'b1
    } pw_mode_e;

endpackage

// File: rtl/pgwr_cycle_timer.sv
module pgwr_cycle_timer
    import pgwr_pkg::*;
#(
    parameter int unsigned CYCLE_CLKS = 250000,
    localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        pw_mode_e         mode;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        last_o = (tmr_q.mode == PW_BUSY) && (tmr_q.cnt == CNT_W'(CYCLE_CLKS - 1));
        unique case (tmr_q.mode)
            PW_IDLE: begin
                if (start_i) begin
                    tmr_d.mode = PW_BUSY;
                    tmr_d.cnt  = '0;
                end
            end
            PW_BUSY: begin
                if (last_o) begin
                    tmr_d.mode = PW_IDLE;
                    tmr_d.cnt  = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
                end
            end
            default: tmr_d = '{mode: PW_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{mode: PW_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o  = (tmr_q.mode == PW_BUSY);
    assign count_o = tmr_q.cnt;

endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int unsigned PAGE_BYTES = 16,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [OFF_W-1:0]      wr_idx_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [OFF_W-1:0]      rd_idx_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [PAGE_BYTES-1:0] mask_o
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes;
        logic [PAGE_BYTES-1:0]             mask;
    } buf_t;

    buf_t                  buf_d, buf_q;
    logic [PAGE_BYTES-1:0] lane_hit;

    // one write decoder per byte lane
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign lane_hit[g] = wr_i && (wr_idx_i == OFF_W'(g));
    end

    always_comb begin
        buf_d = buf_q;
        if (clr_i) begin
            buf_d.mask = '0;
        end
        // a write in the same cycle as a clear survives it
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (lane_hit[i]) begin
                buf_d.bytes[i] = wr_data_i;
                buf_d.mask[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_data_o = buf_q.bytes[rd_idx_i];
    assign mask_o    = buf_q.mask;

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_BYTES = 16,
    parameter int unsigned CYCLE_CLKS = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);

    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;
    localparam int unsigned CNT_W  = $clog2(CYCLE_CLKS + 1);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } ptr_t;

    ptr_t                  ptr_d, ptr_q;
    logic                  accept;
    logic                  ld_addr;
    logic                  ld_data;
    logic [OFF_W-1:0]      wr_idx;
    logic                  cyc_start;
    logic                  buf_clr;
    logic                  tmr_busy;
    logic                  tmr_last;
    logic [CNT_W-1:0]      tmr_count;
    logic [OFF_W-1:0]      scan_idx;
    logic                  in_scan;
    logic [PAGE_BYTES-1:0] vmask;
    logic [DATA_W-1:0]     rd_byte;

    always_comb begin
        ptr_d     = ptr_q;
        accept    = !tmr_busy && !stop_i;
        ld_addr   = addr_vld_i && accept;
        ld_data   = data_vld_i && accept;
        wr_idx    = ld_addr ? addr_i[OFF_W-1:0] : ptr_q.off;
        if (ld_addr) begin
            ptr_d.page = addr_i[ADDR_W-1:OFF_W];
        end
        ptr_d.off = ld_data ? (wr_idx + OFF_W'(1)) : wr_idx;

        cyc_start = stop_i && !tmr_busy && !wp_i && (|vmask);
        buf_clr   = ld_addr || (stop_i && !tmr_busy && wp_i) || tmr_last;

        scan_idx  = tmr_count[OFF_W-1:0];
        in_scan   = (32'(tmr_count) < PAGE_BYTES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    pgwr_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_i      (ld_data),
        .wr_idx_i  (wr_idx),
        .wr_data_i (data_i),
        .rd_idx_i  (scan_idx),
        .rd_data_o (rd_byte),
        .mask_o    (vmask)
    );

    pgwr_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cyc_start),
        .busy_o  (tmr_busy),
        .last_o  (tmr_last),
        .count_o (tmr_count)
    );

    assign busy_o     = tmr_busy;
    assign mem_we_o   = tmr_busy && in_scan && vmask[scan_idx];
    assign mem_addr_o = {ptr_q.page, scan_idx};
    assign mem_data_o = rd_byte;

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_BYTES = 16,
    parameter int unsigned CYCLE_CLKS = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              wp_i,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    localparam int unsigned OFF_W = $clog2(PAGE_BYTES);

    logic [31:0]      win_len_q;
    logic [31:0]      win_wr_q;
    logic             seen_q;
    logic [OFF_W-1:0] last_off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len_q  <= '0;
            win_wr_q   <= '0;
            seen_q     <= 1'b0;
            last_off_q <= '0;
        end else begin
            win_len_q <= busy_o ? win_len_q + 32'd1 : 32'd0;
            win_wr_q  <= busy_o ? win_wr_q + 32'(mem_we_o) : 32'd0;
            if (!busy_o) begin
                seen_q <= 1'b0;
            end else if (mem_we_o) begin
                seen_q     <= 1'b1;
                last_off_q <= mem_addr_o[OFF_W-1:0];
            end
        end
    end

    assert_we_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && seen_q) |-> (mem_addr_o[OFF_W-1:0] > last_off_q));

    assert_write_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (win_wr_q <= 32'(PAGE_BYTES)));

    assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i)));

    assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (win_len_q == 32'(CYCLE_CLKS)));

    assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;

    localparam int CYC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_vld_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic       data_vld_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       stop_i = 1'b0;
    logic       wp_i = 1'b0;
    logic       busy_o;
    logic       mem_we_o;
    logic [7:0] mem_addr_o;
    logic [7:0] mem_data_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] cap [256] = '{default: 8'h00};
    logic [7:0] refm [256] = '{default: 8'h00};
    int         wcount = 0;
    int         order_err = 0;
    int         last_off = -1;

    always #10 clk = ~clk;

    pgwr_ctrl #(
        .ADDR_W     (8),
        .DATA_W     (8),
        .PAGE_BYTES (16),
        .CYCLE_CLKS (CYC)
    ) u_pgwr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_vld_i (addr_vld_i),
        .addr_i     (addr_i),
        .data_vld_i (data_vld_i),
        .data_i     (data_i),
        .stop_i     (stop_i),
        .wp_i       (wp_i),
        .busy_o     (busy_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_data_o (mem_data_o)
    );

    // array model fed by the write port
    always @(posedge clk) begin
        if (!busy_o) last_off <= -1;
        if (mem_we_o) begin
            cap[mem_addr_o] <= mem_data_o;
            wcount          <= wcount + 1;
            if (int'(mem_addr_o[3:0]) <= last_off) order_err <= order_err + 1;
            last_off <= int'(mem_addr_o[3:0]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 5);
    endfunction

    task automatic load_addr(input logic [7:0] a);
        addr_vld_i = 1'b1; addr_i = a;
        @(negedge clk);
        addr_vld_i = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] d);
        data_vld_i = 1'b1; data_i = d;
        @(negedge clk);
        data_vld_i = 1'b0;
    endtask

    task automatic pulse_stop(input bit wp);
        stop_i = 1'b1; wp_i = wp;
        @(negedge clk);
        stop_i = 1'b0; wp_i = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic page_cmp(input int pg, input string req);
        for (int b = 0; b < 16; b++) begin
            chk(cap[pg * 16 + b] == refm[pg * 16 + b], req,
                int'(cap[pg * 16 + b]), int'(refm[pg * 16 + b]));
        end
    endtask

    task automatic run_txn(input int pg, input int off, input int len, input bit wp, input int seed);
        int    w0, o0, n, expw;
        string lbl;
        w0 = wcount; o0 = order_err;
        load_addr(8'(pg * 16 + off));
        for (int i = 0; i < len; i++) put_data(pat(seed, i));
        pulse_stop(wp);
        wait_idle(n);
        lbl = wp ? "R7" : (len == 0 ? "R8" : "R4");
        chk(n == ((len > 0 && !wp) ? CYC : 0), lbl, n, (len > 0 && !wp) ? CYC : 0);
        expw = (len == 0 || wp) ? 0 : (len > 16 ? 16 : len);
        chk(wcount - w0 == expw, "R5", wcount - w0, expw);
        chk(order_err == o0, "R5", order_err - o0, 0);
        if (!wp) begin
            for (int i = 0; i < len; i++) refm[pg * 16 + ((off + i) % 16)] = pat(seed, i);
        end
        page_cmp(pg, "R2/R6");
    endtask

    initial begin
        int n, w0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
        chk(mem_we_o == 1'b0, "R1", int'(mem_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty buffer after reset, a stop starts nothing
        pulse_stop(1'b0);
        chk(busy_o == 1'b0, "R1", int'(busy_o), 0);

        // R2 R4 R5 R6 R7 R8: sweep offset x length
        for (int off = 0; off < 16; off++) begin
            for (int len = 0; len < 18; len++) begin
                run_txn((off * 5 + len) % 16, off, len, ((off + len) % 7) == 3, off * 18 + len);
            end
        end

        // R2: bytes continue at next offset after an idle gap
        load_addr(8'h2E);
        put_data(8'hA1); put_data(8'hA2);
        repeat (5) @(negedge clk);
        put_data(8'hA3);
        pulse_stop(1'b0);
        wait_idle(n);
        refm[8'h2E] = 8'hA1; refm[8'h2F] = 8'hA2; refm[8'h20] = 8'hA3;
        page_cmp(2, "R2");

        // R3: a second address strobe discards earlier bytes
        w0 = wcount;
        load_addr(8'hB0);
        put_data(8'h11); put_data(8'h22); put_data(8'h33);
        load_addr(8'hC4);
        put_data(8'h44);
        pulse_stop(1'b0);
        wait_idle(n);
        chk(wcount - w0 == 1, "R3", wcount - w0, 1);
        refm[8'hC4] = 8'h44;
        page_cmp(11, "R3");
        page_cmp(12, "R3");

        // R7: protected stop empties the buffer
        load_addr(8'hA0);
        put_data(8'h55); put_data(8'h66);
        pulse_stop(1'b1);
        chk(busy_o == 1'b0, "R7", int'(busy_o), 0);
        pulse_stop(1'b0);
        chk(busy_o == 1'b0, "R7", int'(busy_o), 0);
        page_cmp(10, "R7");

        // R9: strobes during the window have no effect
        load_addr(8'h30);
        put_data(8'h77);
        pulse_stop(1'b0);
        chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        load_addr(8'h50);
        put_data(8'h88);
        pulse_stop(1'b0);
        wait_idle(n);
        refm[8'h30] = 8'h77;
        w0 = wcount;
        pulse_stop(1'b0);
        chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
        chk(wcount == w0, "R9", wcount - w0, 0);
        page_cmp(5, "R9");
        page_cmp(3, "R9");

        // R10: strobes in the stop cycle are ignored
        w0 = wcount;
        load_addr(8'h92);
        put_data(8'hC1);
        stop_i = 1'b1; data_vld_i = 1'b1; data_i = 8'hC2;
        addr_vld_i = 1'b1; addr_i = 8'h97;
        @(negedge clk);
        stop_i = 1'b0; data_vld_i = 1'b0; addr_vld_i = 1'b0;
        wait_idle(n);
        chk(wcount - w0 == 1, "R10", wcount - w0, 1);
        refm[8'h92] = 8'hC1;
        page_cmp(9, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
            $finish;
        end
    end

endmodule